// File: doc/BRIEF.md
# Low-Toggle Weighted Pseudorandom Pattern Generator

This block is a self-test stimulus source that keeps switching activity in the scan chains low. A 32-bit maximal-style shift register advances once per shift cycle. Each of its bits passes through its own hold stage. An enabled hold stage copies the fresh bit, and a disabled one keeps its old bit. An XOR phase shifter combines the hold stages and drives one bit per scan chain. Because only some hold stages change in a cycle, only some chain inputs can change.

A toggle mask register selects which hold stages follow the shift register. This mask changes only at a pattern boundary. At that point it is loaded from an auxiliary shift register. During the pattern, the auxiliary register was filled one bit per cycle with weighted-random bits. A 4-bit switching code selects the weight, that is, the expected fraction of toggling stages. The all-zero code turns the power-saving function off. A strobe marks the last shift cycle of every pattern, which is the cycle whose clock edge reloads the mask.

Top module: `lowtog_pattern_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the shift register with `SEED`, sets every mask bit to 1, clears the hold stages and the auxiliary register, and restarts the pattern count. While held in reset, `chain_o` is all zeros and `pat_strobe_o` is 0.
- R2: The shift register state is S. On each edge out of reset it becomes {S[30:0], S[31]^S[21]^S[1]^S[0]}, which realises x^32+x^22+x^2+x+1.
- R3: On each edge, hold bit i takes S[i] when its enable is 1 and keeps its value when its enable is 0. Its enable is mask bit i, unless R6 applies.
- R4: `pat_strobe_o` is high in every PAT_LEN-th cycle after reset and low otherwise. The first high cycle is the PAT_LEN-th cycle after reset. The mask changes only on the edge that ends a strobe cycle. On that edge it takes {A[30:0], w}, where A is the auxiliary register and w is the current weighted bit.
- R5: On every edge the auxiliary register shifts in the weighted bit w. Code bit 3 enables the term S[4]. Code bit 2 enables S[4]&S[9]. Code bit 1 enables S[4]&S[9]&S[14]. Code bit 0 enables S[4]&S[9]&S[14]&S[19]. The enabled terms are ORed, and w is 0 when no term is enabled.
- R6: With switching code 0000, every hold stage is enabled whatever the mask holds.
- R7: `chain_o[j]` is H[j] ^ H[(j+11)%32] ^ H[(j+22)%32], where H is the hold register.
- R8: A change of switching code in the middle of a pattern affects only the weighted bits produced after the change. The mask in use stays the same until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_code | input | 4 | Switching code selecting the enable weight; 0000 disables power saving |
| chain_o | output | NCHAIN | One stimulus bit per scan chain |
| pat_strobe_o | output | 1 | High in the last shift cycle of each pattern |

## Verification
The bench goes after the code 0000 override. A design that ignored it would freeze chain bits behind a stale mask, and the chain outputs would stop following the shift register. It also checks the mask reload boundary: a reload one cycle early or late would make every following pattern's chain values diverge, and the strobe spacing would break. Each code bit is exercised alone and in combination. A reversed weight order or a missing AND input would give the wrong mask at the next boundary. Codes are also changed in the middle of a pattern, which shows whether the mask stays fixed until the boundary.

// File: rtl/lowtog_pkg.sv
package lowtog_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // one shift step for x^32 + x^22 + x^2 + x + 1
    function automatic word_t lfsr_step(word_t s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // hold-register bit feeding input k (0..2) of chain j
    function automatic int ps_tap(int j, int k);
        int off;
        off = (k == 0) ? 0 : ((k == 1) ? 11 : 22);
        return (j + off) % WORD_W;
    endfunction
endpackage

// File: rtl/lowtog_weight.sv
module lowtog_weight
    import lowtog_pkg::*;
#(
    parameter int TAP0 = 4,
    parameter int TAP1 = 9,
    parameter int TAP2 = 14,
    parameter int TAP3 = 19
) (
    input  word_t      lfsr_i,
    input  logic [3:0] code_i,
    output logic       wbit_o,
    output logic       lp_off_o
);
    localparam int NTERM = 4;
    logic [NTERM-1:0] tapv;
    logic [NTERM-1:0] term;

    assign tapv = {lfsr_i[TAP3], lfsr_i[TAP2], lfsr_i[TAP1], lfsr_i[TAP0]};

    // term k ANDs k+1 taps, giving probability 2^-(k+1); code bit 3-k enables it
    for (genvar k = 0; k < NTERM; k++) begin : g_term
        assign term[k] = (&tapv[k:0]) & code_i[NTERM-1-k];
    end

    assign wbit_o   = |term;
    assign lp_off_o = ~|code_i;
endmodule

// File: rtl/lowtog_phase_shift.sv
module lowtog_phase_shift
    import lowtog_pkg::*;
#(
    parameter int NCHAIN = 11
) (
    input  word_t             hold_i,
    output logic [NCHAIN-1:0] chain_o
);
    for (genvar j = 0; j < NCHAIN; j++) begin : g_chain
        localparam int A = ps_tap(j, 0);
        localparam int B = ps_tap(j, 1);
        localparam int C = ps_tap(j, 2);
        assign chain_o[j] = hold_i[A] ^ hold_i[B] ^ hold_i[C];
    end
endmodule

// File: rtl/lowtog_pattern_gen.sv
module lowtog_pattern_gen
    import lowtog_pkg::*;
#(
    parameter int    NCHAIN  = 11,
    parameter int    PAT_LEN = 32,
    parameter word_t SEED    = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        sw_code,
    output logic [NCHAIN-1:0] chain_o,
    output logic              pat_strobe_o
);
    localparam int CNT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAT_LEN - 1);

    typedef struct packed {
        word_t            lfsr;
        word_t            hold;
        word_t            tog;
        word_t            aux;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_q, st_d;
    logic   wbit;
    logic   lp_off;
    logic   last;
    word_t  en;

    lowtog_weight u_weight (
        .lfsr_i   (st_q.lfsr),
        .code_i   (sw_code),
        .wbit_o   (wbit),
        .lp_off_o (lp_off)
    );

    lowtog_phase_shift #(.NCHAIN(NCHAIN)) u_shift (
        .hold_i  (st_q.hold),
        .chain_o (chain_o)
    );

    assign last         = (st_q.cnt == CNT_LAST);
    assign pat_strobe_o = last;

    always_comb begin
        st_d      = st_q;
        en        = lp_off ? '1 : st_q.tog;
        st_d.lfsr = lfsr_step(st_q.lfsr);
        st_d.hold = (st_q.lfsr & en) | (st_q.hold & ~en);
        st_d.aux  = {st_q.aux[WORD_W-2:0], wbit};
        if (last) begin
            st_d.tog = st_d.aux;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d.lfsr = SEED;
            st_d.hold = '0;
            st_d.tog  = '1;
            st_d.aux  = '0;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/lowtog_checker.sv
module lowtog_checker
    import lowtog_pkg::*;
#(
    parameter int NCHAIN = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        sw_code,
    input logic              strobe,
    input logic [NCHAIN-1:0] chain,
    input word_t             lfsr,
    input word_t             hold,
    input word_t             tog
);
    assert_reset_mask_R1: assert property (@(posedge clk)
        rst |=> (tog == '1 && hold == '0 && !strobe));

    assert_lfsr_step_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> lfsr == {$past(lfsr[30:0]),
                          $past(lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0])});

    assert_frozen_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && sw_code != 4'b0000) |=> ((hold ^ $past(hold)) & ~$past(tog)) == '0);

    assert_mask_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && !strobe) |=> $stable(tog));

    assert_all_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && sw_code == 4'b0000) |=> hold == $past(lfsr));

    assert_chain0_xor_R7: assert property (@(posedge clk) disable iff (rst)
        chain[0] == (hold[0] ^ hold[11] ^ hold[22]));
endmodule

bind lowtog_pattern_gen lowtog_checker #(.NCHAIN(NCHAIN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sw_code (sw_code),
    .strobe  (pat_strobe_o),
    .chain   (chain_o),
    .lfsr    (st_q.lfsr),
    .hold    (st_q.hold),
    .tog     (st_q.tog)
);

// File: tb/lowtog_pattern_gen_tb.sv
module lowtog_pattern_gen_tb_top;
    localparam int NCH   = 11;
    localparam int PLEN  = 32;
    localparam logic [31:0] SEED = 32'h1ACE_B00C;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [3:0]     sw_code = 4'b0000;
    logic [NCH-1:0] chain_o;
    logic           pat_strobe_o;

    int n_tests = 0;
    int n_fail  = 0;
    string phase = "R1";

    // behavioural reference state
    logic [31:0] m_lfsr, m_hold, m_tog, m_aux;
    int          m_cnt;
    bit          m_valid = 0;
    int          since_strobe = -1;

    always #10 clk = ~clk;

    lowtog_pattern_gen #(.NCHAIN(NCH), .PAT_LEN(PLEN), .SEED(SEED)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .sw_code      (sw_code),
        .chain_o      (chain_o),
        .pat_strobe_o (pat_strobe_o)
    );

    function automatic logic [NCH-1:0] model_chain(logic [31:0] h);
        logic [NCH-1:0] r;
        for (int j = 0; j < NCH; j++)
            r[j] = h[j] ^ h[(j + 11) % 32] ^ h[(j + 22) % 32];
        return r;
    endfunction

    // weighted bit per R5: code bit 3-k enables the AND of the first k+1 taps
    function automatic logic model_weight(logic [31:0] s, logic [3:0] c);
        int taps[4] = '{4, 9, 14, 19};
        logic w = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (c[3 - k]) begin
                logic t = 1'b1;
                for (int i = 0; i <= k; i++) t = t & s[taps[i]];
                w = w | t;
            end
        end
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual %h expected %h", tag, phase, act, exp);
        end
    endtask

    // compare on every falling edge, then advance the model for the next rising edge
    always @(negedge clk) begin
        if (m_valid) begin
            check("R7 chain", 32'(chain_o), 32'(model_chain(m_hold)));
            check("R4 strobe", 32'(pat_strobe_o), 32'(m_cnt == PLEN - 1));
            if (pat_strobe_o) begin
                if (since_strobe >= 0) check("R4 spacing", since_strobe, PLEN);
                since_strobe = 0;
            end
            if (since_strobe >= 0) since_strobe++;
        end
        if (rst) begin
            m_lfsr = SEED; m_hold = '0; m_tog = '1; m_aux = '0; m_cnt = 0;
            m_valid = 1; since_strobe = -1;
        end else if (m_valid) begin
            logic w;
            logic [31:0] nl;
            w = model_weight(m_lfsr, sw_code);
            for (int i = 0; i < 32; i++)   // R3 and R6
                if (sw_code == 4'b0000 || m_tog[i]) m_hold[i] = m_lfsr[i];
            m_aux = {m_aux[30:0], w};      // R5
            if (m_cnt == PLEN - 1) begin   // R4 reload
                m_tog = m_aux;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            nl = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]}; // R2
            m_lfsr = nl;
        end
    end

    task automatic run(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic set_code(logic [3:0] c);
        @(posedge clk); #2 sw_code = c;
    endtask

    initial begin
        run(3);
        #5;
        check("R1 reset chain", 32'(chain_o), 32'h0);
        check("R1 reset strobe", 32'(pat_strobe_o), 32'h0);
        @(posedge clk); #2 rst = 1'b0;
        phase = "R6"; run(80);
        phase = "R5"; set_code(4'b0100); run(160);
        set_code(4'b1111); run(160);
        set_code(4'b1000); run(100);
        phase = "R3"; set_code(4'b0001); run(160);
        set_code(4'b0010); run(100);
        phase = "R8";
        for (int i = 0; i < 40; i++) begin
            set_code(4'(i * 5 + 3));
            run(6);
        end
        phase = "R1";
        @(posedge clk); #2 rst = 1'b1;
        run(2);
        #5;
        check("R1 re-reset chain", 32'(chain_o), 32'h0);
        @(posedge clk); #2 rst = 1'b0; sw_code = 4'b0110;
        phase = "R2"; run(200);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule